// File: doc/BRIEF.md
# Hierarchical Idle-State Resolver

This block merges low-power idle-state requests from the hardware threads of a multi-core processor into one granted state per core and then into one state for the whole package. Each thread asks for a 2-bit state. For each core, the block takes the shallowest request among that core's threads. It may then demote a deep request, based on how long that core has been asking for deep states. Finally it takes the shallowest core state as the package state.

Configuration inputs turn on the C1E sub-state and the two demotion options, and set the two residency thresholds. When the package settles in C1E, a flag asks the power controller to move to the lowest core clock frequency first and to lower the voltage afterwards. A per-core enable removes a core from the resolution entirely. All outputs are registered and follow the inputs with one cycle of latency.

Top module: `idle_state_resolver`

## Requirements
- R1: Thread requests are coded 0 = C0, 1 = C1, 2 = C3, 3 = C6. Core and package outputs are coded 0 = C0, 1 = C1, 2 = C1E, 3 = C3, 4 = C6. Thread t of core c occupies bits [(c*THREADS+t)*2 +: 2] of `thread_req`, and core c occupies bits [c*3 +: 3] of `core_state`.
- R2: The state of an enabled core is the shallowest request among its threads. A C0 request from any of its threads forces that core to C0.
- R3: The package state is the shallowest state among the enabled cores, using the output coding order.
- R4: A core whose `core_en` bit is low has its thread requests ignored. It reports C6, does not hold the package above C6, and its residency count is cleared. With no core enabled, the package reports C6.
- R5: With `c1e_en` high, a core or package result of C1 is reported as C1E only when no enabled core resolves to C0 after demotion. Otherwise it stays C1. With `c1e_en` low, C1E never appears.
- R6: `low_freq_req` is high exactly when the package output is C1E.
- R7: Each core has a saturating residency counter of RES_W bits. It increments on every cycle that the core's merged thread request is C3 or C6. It holds on a C1 request. It clears on a C0 request or when the core is disabled. It never wraps.
- R8: With `dem_c1_en` high and the core's count below `thr_c1`, a C3 or C6 request is granted as C1.
- R9: With `dem_c3_en` high, a C6 request whose count is below `thr_c3` is granted as C3, unless R8 applies. R8 takes priority over R9.
- R10: With both demotion options low, C3 and C6 requests are granted unchanged, whatever the count.
- R11: Outputs change on the clock edge after the inputs that cause them. A synchronous active-low reset sets every core and the package to C0, clears `low_freq_req` and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_req | input | NUM_CORES*THREADS*2 | Per-thread requested state |
| core_en | input | NUM_CORES | Per-core enable |
| c1e_en | input | 1 | Enables C1E reporting |
| dem_c1_en | input | 1 | Enables demotion of C3/C6 to C1 |
| dem_c3_en | input | 1 | Enables demotion of C6 to C3 |
| thr_c1 | input | RES_W | Residency needed to escape C1 demotion |
| thr_c3 | input | RES_W | Residency needed to escape C3 demotion |
| core_state | output | NUM_CORES*3 | Granted state of each core |
| pkg_state | output | 3 | Package state |
| low_freq_req | output | 1 | Request for the lowest frequency, then reduced voltage |

## Verification
Several properties are checked on every cycle. A C0 thread forces its core to C0 on the next cycle. A disabled core reports C6. The package is never deeper than any core. C1E never coexists with a core in C0, and the low-frequency flag stays low while C1E is off. The counters clear on C0, hold on C1, and are never demoted without cause.

Other behaviour can only be shown by the bench's scenarios, which run against a cycle-level model: the exact cycle on which a demoted grant is lifted, the priority between the two demotion options when both are on, counter saturation over long deep residency, and recovery after a mid-run reset.

// File: rtl/idle_pkg.sv
// Shared codes and types for the idle-state resolver.
// Request codes order by depth; output codes insert C1E between C1 and C3
// so that "shallowest wins" is a plain numeric minimum at both levels.
package idle_pkg;
    localparam int REQ_W = 2;
    localparam int ST_W  = 3;

    typedef logic [REQ_W-1:0] req_t;
    typedef logic [ST_W-1:0]  state_t;

    localparam req_t REQ_C0 = 2'd0;
    localparam req_t REQ_C1 = 2'd1;
    localparam req_t REQ_C3 = 2'd2;
    localparam req_t REQ_C6 = 2'd3;

    localparam state_t ST_C0  = 3'd0;
    localparam state_t ST_C1  = 3'd1;
    localparam state_t ST_C1E = 3'd2;
    localparam state_t ST_C3  = 3'd3;
    localparam state_t ST_C6  = 3'd4;
endpackage

// File: rtl/thread_merge.sv
// Merges the thread requests of one core into the shallowest request.
// Assumes request codes grow with depth. A disabled core yields C6 so
// that it cannot hold anything shallower above it.
module thread_merge
    import idle_pkg::*;
#(
    parameter int THREADS = 2
) (
    input  logic [THREADS*REQ_W-1:0] reqs,
    input  logic                     en,
    output req_t                     merged
);
    // Numeric minimum over the enabled core's threads.
    always_comb begin
        merged = REQ_C6;
        if (en) begin
            for (int t = 0; t < THREADS; t++) begin
                if (reqs[t*REQ_W +: REQ_W] < merged)
                    merged = reqs[t*REQ_W +: REQ_W];
            end
        end
    end
endmodule

// File: rtl/core_demote.sv
// Per-core residency tracking and auto-demotion of deep requests.
// Counts cycles of deep (C3/C6) requests, saturating; C1 holds the count,
// C0 or disable clears it. Grant is combinational; the caller registers it.
module core_demote
    import idle_pkg::*;
#(
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  req_t             req,
    input  logic             en,
    input  logic             dem_c1_en,
    input  logic             dem_c3_en,
    input  logic [RES_W-1:0] thr_c1,
    input  logic [RES_W-1:0] thr_c3,
    output state_t           grant
);
    localparam logic [RES_W-1:0] CNT_MAX = '1;

    logic [RES_W-1:0] cnt;
    logic             to_c1;
    logic             to_c3;

    // Residency counter: clear on C0/disable, saturate on deep requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || req == REQ_C0)
            cnt <= '0;
        else if (req >= REQ_C3 && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign to_c1 = dem_c1_en && (cnt < thr_c1);
    assign to_c3 = dem_c3_en && (cnt < thr_c3);

    // Grant selection: C1 demotion outranks C3 demotion.
    always_comb begin
        grant = ST_C6;
        if (en) begin
            case (req)
                REQ_C0:  grant = ST_C0;
                REQ_C1:  grant = ST_C1;
                REQ_C3:  grant = to_c1 ? ST_C1 : ST_C3;
                default: grant = to_c1 ? ST_C1 : (to_c3 ? ST_C3 : ST_C6);
            endcase
        end
    end

    a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!en || req == REQ_C0) |-> cnt == '0);

    a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en && req == REQ_C1) |-> $stable(cnt));

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en && req >= REQ_C3) |-> cnt >= $past(cnt));
endmodule

// File: rtl/pkg_combine.sv
// Applies the C1E rule, resolves the package state and registers all outputs.
// Assumes disabled cores already present C6 on their grant.
module pkg_combine
    import idle_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES*ST_W-1:0] grant,
    input  logic                      c1e_en,
    output logic [NUM_CORES*ST_W-1:0] core_state,
    output state_t                    pkg_state,
    output logic                      low_freq_req
);
    logic                      all_ge_c1;
    logic [NUM_CORES*ST_W-1:0] shown;
    state_t                    pkg_n;

    // True when no core resolved to C0.
    always_comb begin
        all_ge_c1 = 1'b1;
        for (int i = 0; i < NUM_CORES; i++)
            if (grant[i*ST_W +: ST_W] == ST_C0) all_ge_c1 = 1'b0;
    end

    // Per-core C1 to C1E promotion and package minimum.
    always_comb begin
        pkg_n = ST_C6;
        for (int i = 0; i < NUM_CORES; i++) begin
            shown[i*ST_W +: ST_W] = grant[i*ST_W +: ST_W];
            if (c1e_en && all_ge_c1 && grant[i*ST_W +: ST_W] == ST_C1)
                shown[i*ST_W +: ST_W] = ST_C1E;
            if (shown[i*ST_W +: ST_W] < pkg_n)
                pkg_n = shown[i*ST_W +: ST_W];
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_state   <= '0;
            pkg_state    <= ST_C0;
            low_freq_req <= 1'b0;
        end else begin
            core_state   <= shown;
            pkg_state    <= pkg_n;
            low_freq_req <= (pkg_n == ST_C1E);
        end
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
        a_r3_pkg_shallowest: assert property (@(posedge clk) disable iff (!rst_n)
            pkg_state <= core_state[i*ST_W +: ST_W]);
        a_r5_c1e_no_c0_core: assert property (@(posedge clk) disable iff (!rst_n)
            pkg_state == ST_C1E |-> core_state[i*ST_W +: ST_W] != ST_C0);
    end

    a_r6_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(c1e_en) |-> !low_freq_req);

    a_r6_flag_pkg: assert property (@(posedge clk) disable iff (!rst_n)
        low_freq_req |-> core_state != '0);
endmodule

// File: rtl/idle_state_resolver.sv
// Top: two-level idle-state resolution (threads to cores, cores to package)
// with residency-based demotion and C1E promotion. One register stage.
module idle_state_resolver
    import idle_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int THREADS   = 2,
    parameter int RES_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CORES*THREADS*2-1:0]    thread_req,
    input  logic [NUM_CORES-1:0]              core_en,
    input  logic                              c1e_en,
    input  logic                              dem_c1_en,
    input  logic                              dem_c3_en,
    input  logic [RES_W-1:0]                  thr_c1,
    input  logic [RES_W-1:0]                  thr_c3,
    output logic [NUM_CORES*3-1:0]            core_state,
    output logic [2:0]                        pkg_state,
    output logic                              low_freq_req
);
    localparam int TREQ_W = THREADS * REQ_W;

    logic [NUM_CORES*REQ_W-1:0] merged;
    logic [NUM_CORES*ST_W-1:0]  grant;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic thr_c0;

        thread_merge #(.THREADS(THREADS)) u_merge (
            .reqs   (thread_req[c*TREQ_W +: TREQ_W]),
            .en     (core_en[c]),
            .merged (merged[c*REQ_W +: REQ_W])
        );

        core_demote #(.RES_W(RES_W)) u_dem (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (merged[c*REQ_W +: REQ_W]),
            .en        (core_en[c]),
            .dem_c1_en (dem_c1_en),
            .dem_c3_en (dem_c3_en),
            .thr_c1    (thr_c1),
            .thr_c3    (thr_c3),
            .grant     (grant[c*ST_W +: ST_W])
        );

        // Flags any thread of this core asking for C0 (used by checks only).
        always_comb begin
            thr_c0 = 1'b0;
            for (int t = 0; t < THREADS; t++)
                if (thread_req[(c*THREADS+t)*REQ_W +: REQ_W] == REQ_C0) thr_c0 = 1'b1;
        end

        a_r2_c0_wins: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(core_en[c] && thr_c0) |-> core_state[c*ST_W +: ST_W] == ST_C0);

        a_r4_disabled_c6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(core_en[c]) |-> core_state[c*ST_W +: ST_W] == ST_C6);

        a_r10_no_demote: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(core_en[c] && !dem_c1_en && !dem_c3_en
                                  && merged[c*REQ_W +: REQ_W] == REQ_C6)
            |-> core_state[c*ST_W +: ST_W] == ST_C6);
    end

    pkg_combine #(.NUM_CORES(NUM_CORES)) u_pkg (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .c1e_en       (c1e_en),
        .core_state   (core_state),
        .pkg_state    (pkg_state),
        .low_freq_req (low_freq_req)
    );
endmodule

// File: tb/tb_idle_state_resolver.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one input set per cycle and queues
// the expected outputs from a requirement-level model; the monitor compares.
module tb_idle_state_resolver;
    localparam int NC = 2;
    localparam int NT = 2;
    localparam int RW = 4;
    localparam int T1 = 5;
    localparam int T3 = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC*NT*2-1:0] thread_req = '0;
    logic [NC-1:0]   core_en = '1;
    logic            c1e_en = 1'b0, dem_c1_en = 1'b0, dem_c3_en = 1'b0;
    logic [RW-1:0]   thr_c1 = RW'(T1);
    logic [RW-1:0]   thr_c3 = RW'(T3);
    logic [NC*3-1:0] core_state;
    logic [2:0]      pkg_state;
    logic            low_freq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int cnt_m [NC];

    logic [NC*3-1:0] q_cs [$];
    logic [2:0]      q_ps [$];
    logic            q_lf [$];
    string           q_tag [$];

    always #5 clk = ~clk;

    idle_state_resolver #(.NUM_CORES(NC), .THREADS(NT), .RES_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .thread_req(thread_req), .core_en(core_en),
        .c1e_en(c1e_en), .dem_c1_en(dem_c1_en), .dem_c3_en(dem_c3_en),
        .thr_c1(thr_c1), .thr_c3(thr_c3), .core_state(core_state),
        .pkg_state(pkg_state), .low_freq_req(low_freq_req));

    function automatic logic [7:0] mk(int a, int b, int c, int d);
        return {d[1:0], c[1:0], b[1:0], a[1:0]};
    endfunction

    // Reset cycle: everything C0, model counters cleared (R11).
    task automatic reset_cycle();
        @(negedge clk);
        rst_n = 1'b0;
        q_cs.push_back('0); q_ps.push_back(3'd0); q_lf.push_back(1'b0);
        q_tag.push_back("R11 reset");
        for (int c = 0; c < NC; c++) cnt_m[c] = 0;
    endtask

    // One driven cycle with expected values from the requirement model.
    task automatic drive(input logic [7:0] rq, input logic [1:0] en,
                         input logic c1e, input logic d1, input logic d3,
                         input string tag);
        int r [NC];
        int g [NC];
        int s [NC];
        int pk;
        bit allge;
        logic [NC*3-1:0] cs;
        @(negedge clk);
        rst_n = 1'b1; thread_req = rq; core_en = en;
        c1e_en = c1e; dem_c1_en = d1; dem_c3_en = d3;
        allge = 1'b1;
        for (int c = 0; c < NC; c++) begin
            r[c] = 3;
            if (en[c])
                for (int t = 0; t < NT; t++)
                    if (int'(rq[(c*NT+t)*2 +: 2]) < r[c]) r[c] = int'(rq[(c*NT+t)*2 +: 2]);
            if (!en[c]) g[c] = 4;
            else if (r[c] == 0) g[c] = 0;
            else if (r[c] == 1) g[c] = 1;
            else if (d1 && cnt_m[c] < T1) g[c] = 1;
            else if (r[c] == 2) g[c] = 3;
            else if (d3 && cnt_m[c] < T3) g[c] = 3;
            else g[c] = 4;
            if (g[c] == 0) allge = 1'b0;
        end
        pk = 4;
        for (int c = 0; c < NC; c++) begin
            s[c] = (g[c] == 1 && c1e && allge) ? 2 : g[c];
            if (s[c] < pk) pk = s[c];
            cs[c*3 +: 3] = 3'(s[c]);
        end
        q_cs.push_back(cs); q_ps.push_back(3'(pk)); q_lf.push_back(pk == 2);
        q_tag.push_back(tag);
        for (int c = 0; c < NC; c++) begin
            if (!en[c] || r[c] == 0) cnt_m[c] = 0;
            else if (r[c] >= 2 && cnt_m[c] < (1 << RW) - 1) cnt_m[c]++;
        end
    endtask

    // Monitor: compares each registered result just after its clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_ps.size() > 0) begin
                logic [NC*3-1:0] ecs;
                logic [2:0] eps;
                logic elf;
                string tg;
                ecs = q_cs.pop_front(); eps = q_ps.pop_front();
                elf = q_lf.pop_front(); tg = q_tag.pop_front();
                checks += 3;
                if (core_state !== ecs) begin
                    failures++;
                    $display("FAIL %s core_state actual=%h expected=%h", tg, core_state, ecs);
                end
                if (pkg_state !== eps) begin
                    failures++;
                    $display("FAIL %s pkg_state actual=%0d expected=%0d", tg, pkg_state, eps);
                end
                if (low_freq_req !== elf) begin
                    failures++;
                    $display("FAIL %s/R6 low_freq_req actual=%0b expected=%0b", tg, low_freq_req, elf);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        reset_cycle(); reset_cycle();
        // R1/R2: codes and per-core minimum, demotion and C1E off.
        drive(mk(1, 2, 2, 3), 2'b11, 0, 0, 0, "R1/R2 min");
        drive(mk(3, 0, 3, 3), 2'b11, 0, 0, 0, "R2 c0 wins");
        // R3: package is shallowest core.
        drive(mk(3, 3, 2, 3), 2'b11, 0, 0, 0, "R3 pkg min");
        drive(mk(1, 3, 3, 3), 2'b11, 0, 0, 0, "R3 pkg c1");
        // R5: C1E when all cores at C1 or deeper; blocked by a C0 core.
        drive(mk(1, 1, 1, 2), 2'b11, 1, 0, 0, "R5 c1e all");
        drive(mk(1, 1, 0, 1), 2'b11, 1, 0, 0, "R5 c1e blocked");
        drive(mk(1, 3, 3, 3), 2'b11, 1, 0, 0, "R5 c1e pkg");
        // R4: disabled cores ignored.
        drive(mk(1, 3, 0, 0), 2'b01, 1, 0, 0, "R4 one off");
        drive(mk(0, 0, 1, 1), 2'b00, 0, 0, 0, "R4 all off");
        drive(mk(0, 0, 0, 0), 2'b11, 0, 0, 0, "R7 clear");
        // R8: C1 demotion until residency reaches thr_c1.
        for (int i = 0; i < 8; i++) drive(mk(3, 3, 2, 2), 2'b11, 0, 1, 0, "R8 demote c1");
        drive(mk(0, 0, 0, 0), 2'b11, 0, 0, 0, "R7 clear");
        // R9: C6 to C3 demotion only.
        for (int i = 0; i < 12; i++) drive(mk(3, 3, 2, 3), 2'b11, 0, 0, 1, "R9 demote c3");
        drive(mk(0, 0, 0, 0), 2'b11, 0, 0, 0, "R7 clear");
        // R9: both options, C1 first, then C3, then C6.
        for (int i = 0; i < 13; i++) drive(mk(3, 3, 3, 3), 2'b11, 1, 1, 1, "R9 priority");
        drive(mk(0, 0, 0, 0), 2'b11, 0, 0, 0, "R7 clear");
        // R7: C1 holds the count.
        for (int i = 0; i < 3; i++) drive(mk(3, 3, 3, 3), 2'b11, 0, 1, 0, "R7 deep");
        for (int i = 0; i < 5; i++) drive(mk(1, 3, 1, 3), 2'b11, 0, 1, 0, "R7 hold");
        for (int i = 0; i < 4; i++) drive(mk(3, 3, 3, 3), 2'b11, 0, 1, 0, "R7 resume");
        // R7: saturation, a wrap would bring demotion back.
        for (int i = 0; i < 22; i++) drive(mk(3, 3, 3, 3), 2'b11, 0, 1, 1, "R7 saturate");
        drive(mk(0, 0, 0, 0), 2'b11, 0, 0, 0, "R7 clear");
        // R10: no demotion with both options off.
        for (int i = 0; i < 3; i++) drive(mk(3, 3, 2, 2), 2'b11, 0, 0, 0, "R10 off");
        // R11: mid-run reset, then recovery.
        reset_cycle();
        drive(mk(1, 1, 1, 1), 2'b11, 1, 0, 0, "R11 after reset");
        drive(mk(3, 3, 3, 3), 2'b11, 0, 1, 0, "R11 counters cleared");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule